// File: doc/BRIEF.md
# I2S Audio Transmitter

This block turns audio samples into an I2S serial stream. The stream has a bit clock, a word-select line and a serial data line. Samples enter through a push port into a small internal queue. A 16-bit control word fixes the sample width, mono or stereo framing, muting, a stop mode, a channel clear, the timing role and the word-select half length. The block shifts each word out MSB first. The first data bit follows each word-select edge by one bit clock. Word select low marks the left channel.

In master mode the block makes the bit clock itself: it toggles once on every system clock cycle with `clk_en` high. It changes word select and data on the falling bit-clock edges, so a receiver samples on rising edges. Each word-select half lasts the programmed count plus one bit clocks, whatever the sample width. In slave mode an external bit clock and word select drive the same framing logic. The block then finds the word boundaries from the external word-select edges. If a half holds more bit slots than the sample has bits, the spare slots carry zeros. If it holds fewer, the sample is cut after its leading bits.

Top module: `i2s_audio_tx`

## Requirements
- R1: After `rst`, `ctl_rdata` reads 0x321F, and `sck_out`, `ws_out`, `sd_out`, `underflow` and `push_full` are 0. The control field layout is: bits [8:0] half-length minus one, [10:9] width code, [11] mono, [12] mute, [13] stop, [14] slave role, [15] channel clear.
- R2: Width code 0 sends 8 bits and code 1 sends 16 bits, taken from the low bits of the pushed word. Code 3 sends all 32 bits. The reserved code 2 acts as code 1.
- R3: In master mode `sck_out` toggles on every clock cycle with `clk_en` high. `ws_out` changes only on falling `sck_out` edges, and each of its halves lasts (half field + 1) bit clocks. `ws_out` low is the left channel.
- R4: Data leaves MSB first on falling bit-clock edges. The first bit of a word is sent in the bit slot after the word-select edge, and the slot carrying that edge holds the last bit slot of the previous half.
- R5: If a half has more slots than the sample width, the extra slots send 0. If it has fewer, only the leading bits of the sample are sent.
- R6: In stereo mode, queue samples go out in order, alternating left then right. In mono mode, each sample is sent in both the left and the right half of one frame.
- R7: With mute set, every data slot is 0 while framing runs unchanged, and the queue is still consumed at the normal rate.
- R8: With stop set, every data slot is 0, no sample is taken from the queue, and no underflow is flagged.
- R9: A word needed while the queue is empty is sent as zeros and sets `underflow`. The flag stays set until a channel clear or `rst`.
- R10: While the clear bit is 1, the queue is empty, `underflow` is 0 and framing is held at its start (`sck_out` low). When the bit drops, framing restarts with a left half.
- R11: In slave mode, data changes after falling `sck_in` edges. A half starts at each `ws_in` change seen on a falling edge, and `ws_out` follows `ws_in`.
- R12: The queue holds `FIFO_DEPTH` words and `push_full` is 1 when it is full. A push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Master bit-clock half-period enable |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word to write |
| ctl_rdata | output | 16 | Current control word |
| push_valid | input | 1 | Push a sample into the queue |
| push_data | input | 32 | Sample, right-aligned |
| push_full | output | 1 | Queue full |
| sck_in | input | 1 | External bit clock (slave role) |
| ws_in | input | 1 | External word select (slave role) |
| sck_out | output | 1 | Generated bit clock (master role) |
| ws_out | output | 1 | Word select |
| sd_out | output | 1 | Serial data |
| underflow | output | 1 | Sticky underflow flag |

## Verification
A push into the queue and the serializer taking a word can land in the same clock cycle. The queue count and the full flag must then stay consistent. To make this happen, samples are fed during live framing with random gaps, so the queue hovers near empty and some pushes fall on the cycle that loads a word. The outcome is judged on the serial stream: the bench rebuilds every bit slot from the sample order it pushed, and any lost, repeated or reordered sample shows up as a slot mismatch. It is judged also on the underflow flag staying clear.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

    localparam int HALF_W   = 9;
    localparam int SAMPLE_W = 32;
    localparam int CTL_W    = 16;

    typedef enum logic [1:0] {
        WID_8    = 2'd0,
        WID_16   = 2'd1,
        WID_RSVD = 2'd2,
        WID_32   = 2'd3
    } width_e;

    typedef struct packed {
        logic              clear;
        logic              slave;
        logic              stop;
        logic              mute;
        logic              mono;
        width_e            width;
        logic [HALF_W-1:0] half;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        clear: 1'b0,
        slave: 1'b0,
        stop:  1'b1,
        mute:  1'b1,
        mono:  1'b0,
        width: WID_16,
        half:  9'd31
    };

    // Place the active sample bits at the top of a shift word.
    function automatic logic [SAMPLE_W-1:0] align_left(input width_e w,
                                                       input logic [SAMPLE_W-1:0] d);
        logic [SAMPLE_W-1:0] r;
        case (w)
            WID_8:   r = {d[7:0], 24'b0};
            WID_32:  r = d;
            default: r = {d[15:0], 16'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/i2stx_fifo.sv
module i2stx_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       push,
    input  logic [DW-1:0]              din,
    input  logic                       pop,
    output logic [DW-1:0]              dout,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          wr_ok, rd_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign wr_ok = push && !full;
    assign rd_ok = pop && !empty;
    assign dout  = mem[rp];
    assign count = cnt;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= ptr_next(wp);
            if (rd_ok) rp <= ptr_next(rp);
            unique case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        ($past(full) && $past(push) && !$past(pop) && !$past(clr)) |-> (cnt == $past(cnt))); // R12

endmodule

// File: rtl/i2stx_framer.sv
module i2stx_framer #(
    parameter int HW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          slave,
    input  logic          clk_en,
    input  logic [HW-1:0] half,
    input  logic          sck_in,
    input  logic          ws_in,
    output logic          sck_o,
    output logic          ws_o,
    output logic          tick,
    output logic          load,
    output logic          load_right
);
    localparam logic [HW-1:0] CNT_MAX = '1;
    localparam logic [HW-1:0] CNT_ONE = HW'(1);

    logic          sck_r, ws_r, sck_in_q, ws_nxt;
    logic [HW-1:0] cnt, cnt_nxt;

    always_comb begin
        tick = slave ? (sck_in_q && !sck_in) : (clk_en && sck_r);
        if (slave) begin
            ws_nxt  = ws_in;
            if (ws_in != ws_r)       cnt_nxt = '0;
            else if (cnt == CNT_MAX) cnt_nxt = cnt;
            else                     cnt_nxt = cnt + 1'b1;
        end else if (cnt >= half) begin
            ws_nxt  = !ws_r;
            cnt_nxt = '0;
        end else begin
            ws_nxt  = ws_r;
            cnt_nxt = cnt + 1'b1;
        end
        load       = tick && (cnt_nxt == CNT_ONE);
        load_right = ws_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sck_r    <= 1'b0;
            ws_r     <= 1'b0;
            cnt      <= '0;
            sck_in_q <= 1'b0;
        end else begin
            sck_in_q <= sck_in;
            if (tick) begin
                ws_r <= ws_nxt;
                cnt  <= cnt_nxt;
            end
            if (slave)       sck_r <= 1'b0;
            else if (clk_en) sck_r <= !sck_r;
        end
    end

    assign sck_o = sck_r;
    assign ws_o  = ws_r;

    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (ws_r != $past(ws_r)) |-> ($past(tick) || $past(clr))); // R3

endmodule

// File: rtl/i2stx_shifter.sv
module i2stx_shifter #(
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic          load,
    input  logic [SW-1:0] word,
    output logic          sd
);
    logic [SW-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh <= '0;
            sd <= 1'b0;
        end else if (tick) begin
            if (load) begin
                sd <= word[SW-1];
                sh <= {word[SW-2:0], 1'b0};
            end else begin
                sd <= sh[SW-1];
                sh <= {sh[SW-2:0], 1'b0};
            end
        end
    end

    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (sd != $past(sd)) |-> ($past(tick) || $past(clr))); // R4

endmodule

// File: rtl/i2s_audio_tx.sv
module i2s_audio_tx
    import i2stx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_en,
    input  logic                ctl_wr,
    input  logic [CTL_W-1:0]    ctl_wdata,
    output logic [CTL_W-1:0]    ctl_rdata,
    input  logic                push_valid,
    input  logic [SAMPLE_W-1:0] push_data,
    output logic                push_full,
    input  logic                sck_in,
    input  logic                ws_in,
    output logic                sck_out,
    output logic                ws_out,
    output logic                sd_out,
    output logic                underflow
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    ctl_t                ctl_q;
    logic                clr;
    logic                tick, load, load_right, need_pop;
    logic                fifo_empty;
    logic [CW-1:0]       fifo_cnt;
    logic [SAMPLE_W-1:0] fifo_dout, head_al, word_raw, word_tx, held;
    logic                uflow_q;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= CTL_RESET;
        else if (ctl_wr) ctl_q <= ctl_t'(ctl_wdata);
    end

    assign ctl_rdata = ctl_q;
    assign clr       = ctl_q.clear;

    i2stx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .DW    (SAMPLE_W)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .push  (push_valid),
        .din   (push_data),
        .pop   (need_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (push_full),
        .count (fifo_cnt)
    );

    i2stx_framer #(
        .HW (HALF_W)
    ) u_framer (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .slave      (ctl_q.slave),
        .clk_en     (clk_en),
        .half       (ctl_q.half),
        .sck_in     (sck_in),
        .ws_in      (ws_in),
        .sck_o      (sck_out),
        .ws_o       (ws_out),
        .tick       (tick),
        .load       (load),
        .load_right (load_right)
    );

    // Word selection: fresh sample, repeated mono sample, or silence.
    assign head_al  = align_left(ctl_q.width, fifo_dout);
    assign need_pop = load && !ctl_q.stop && (!load_right || !ctl_q.mono);

    always_comb begin
        word_raw = '0;
        if (need_pop) begin
            word_raw = fifo_empty ? '0 : head_al;
        end else if (load && load_right && ctl_q.mono) begin
            word_raw = held;
        end
        word_tx = (ctl_q.mute || ctl_q.stop) ? '0 : word_raw;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            held    <= '0;
            uflow_q <= 1'b0;
        end else begin
            if (need_pop && !load_right) held <= word_raw;
            if (need_pop && fifo_empty)  uflow_q <= 1'b1;
        end
    end

    assign underflow = uflow_q;

    i2stx_shifter #(
        .SW (SAMPLE_W)
    ) u_shifter (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .tick (tick),
        .load (load),
        .word (word_tx),
        .sd   (sd_out)
    );

    AST_STOP_HOLDS_QUEUE: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl_q.stop) && !$past(clr) && !$past(push_valid && !push_full))
        |-> (fifo_cnt == $past(fifo_cnt))); // R8

    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(uflow_q) && !$past(clr)) |-> uflow_q); // R9

endmodule

// File: tb/test_i2s_audio_tx.sv
module test_i2s_audio_tx;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        push_valid = 1'b0;
    logic [31:0] push_data = '0;
    logic        push_full;
    logic        sck_in = 1'b0;
    logic        ws_in = 1'b0;
    logic        sck_out, ws_out, sd_out, underflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state for the expected stream.
    int          m_half, m_w, m_n;
    bit          m_mono, m_silent;
    logic [31:0] smp [16];
    logic        cap_ws [1024];
    logic        cap_sd [1024];

    always #(CLK_PERIOD/2) clk = !clk;

    i2s_audio_tx #(.FIFO_DEPTH(DEPTH)) i_i2s_audio_tx (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .ctl_rdata  (ctl_rdata),
        .push_valid (push_valid),
        .push_data  (push_data),
        .push_full  (push_full),
        .sck_in     (sck_in),
        .ws_in      (ws_in),
        .sck_out    (sck_out),
        .ws_out     (ws_out),
        .sd_out     (sd_out),
        .underflow  (underflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] cfg(input int half, input int wcode, input bit mono,
                                        input bit mute, input bit stop, input bit slave,
                                        input bit clear);
        logic [8:0] h = half[8:0];
        logic [1:0] w = wcode[1:0];
        return {clear, slave, stop, mute, mono, w, h};
    endfunction

    function automatic bit exp_bit(input int h, input int i);
        int si = m_mono ? h / 2 : h;
        if (m_silent || si >= m_n || i >= m_w) return 1'b0;
        return smp[si][m_w-1-i];
    endfunction

    function automatic bit exp_sd(input int k);
        int c, h;
        if (k == 0) return 1'b0;
        c = k % (m_half + 1);
        h = k / (m_half + 1);
        if (c >= 1) return exp_bit(h, c - 1);
        return exp_bit(h - 1, m_half);
    endfunction

    function automatic bit exp_ws(input int k);
        return bit'((k / (m_half + 1)) % 2);
    endfunction

    task automatic write_ctl(input logic [15:0] v);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic setup(input int half, input int wcode, input bit mono,
                         input bit mute, input bit stop, input bit slave);
        clk_en = 1'b0;
        sck_in = 1'b0;
        ws_in  = 1'b0;
        write_ctl(cfg(half, wcode, mono, mute, stop, slave, 1'b1));
        write_ctl(cfg(half, wcode, mono, mute, stop, slave, 1'b0));
        m_half   = half;
        m_w      = (wcode == 0) ? 8 : (wcode == 3) ? 32 : 16;
        m_mono   = mono;
        m_silent = mute || stop;
        for (int i = 0; i < 16; i++) smp[i] = $urandom;
    endtask

    // Pushes samples with random gaps while framing runs.
    task automatic feed(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            push_valid = 1'b0;
            if (i > 0) repeat ($urandom % (m_half + 1)) @(negedge clk);
            while (push_full) @(negedge clk);
            push_valid = 1'b1;
            push_data  = smp[i];
        end
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic cap_master(input int nslots);
        int   k = 0;
        logic prev;
        @(negedge clk);
        clk_en = 1'b1;
        prev = sck_out;
        while (k < nslots) begin
            @(negedge clk);
            if (sck_out && !prev) begin
                cap_ws[k] = ws_out;
                cap_sd[k] = sd_out;
                k++;
                if (k == nslots) clk_en = 1'b0;
            end
            prev = sck_out;
        end
    endtask

    task automatic cap_slave(input int nslots);
        for (int k = 0; k < nslots; k++) begin
            @(negedge clk);
            cap_ws[k] = ws_out;
            cap_sd[k] = sd_out;
            sck_in = 1'b1;
            repeat (2) @(negedge clk);
            sck_in = 1'b0;
            ws_in  = exp_ws(k + 1);
            @(negedge clk);
        end
    endtask

    task automatic compare(input int nslots, input string req);
        int bad = 0;
        int slot = 0;
        int act = 0;
        int exp = 0;
        for (int k = 0; k < nslots; k++) begin
            if (cap_ws[k] !== exp_ws(k) || cap_sd[k] !== exp_sd(k)) begin
                if (bad == 0) begin
                    slot = k;
                    act  = {cap_ws[k], cap_sd[k]};
                    exp  = {exp_ws(k), exp_sd(k)};
                end
                bad++;
            end
        end
        check(bad == 0, req, $sformatf("stream {ws,sd} first bad slot %0d of %0d bad", slot, bad),
              act, exp);
    endtask

    task automatic run_master(input int half, input int wcode, input bit mono, input bit mute,
                              input bit stop, input int n, input int k_halves, input string req);
        int nslots = 1 + k_halves * (half + 1);
        int pops   = mono ? (k_halves + 1) / 2 : k_halves;
        bit uf_exp;
        setup(half, wcode, mono, mute, stop, 1'b0);
        m_n = stop ? 0 : n;
        fork
            feed(n);
            begin
                repeat (3) @(negedge clk);
                cap_master(nslots);
            end
        join
        compare(nslots, req);
        uf_exp = !stop && (pops > n);
        check(underflow == uf_exp, "R9", {"underflow flag after ", req}, underflow, uf_exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        check(ctl_rdata == 16'h321F, "R1", "control word after reset", ctl_rdata, 16'h321F);
        check({sck_out, ws_out, sd_out} == 3'b000, "R1", "serial lines after reset",
              {sck_out, ws_out, sd_out}, 0);
        check(!underflow && !push_full, "R1", "flags after reset", {underflow, push_full}, 0);

        // Directed streams
        run_master(31, 1, 1'b0, 1'b0, 1'b0, 4, 4, "R3 R4 16-bit stereo 64-clock frame");
        run_master(11, 3, 1'b0, 1'b0, 1'b0, 4, 4, "R5 R2 32-bit truncated");
        run_master(15, 0, 1'b0, 1'b0, 1'b0, 4, 4, "R5 R2 8-bit padded");
        run_master(20, 2, 1'b0, 1'b0, 1'b0, 4, 4, "R2 reserved code acts as 16-bit");
        run_master(17, 1, 1'b1, 1'b0, 1'b0, 3, 6, "R6 mono repeat");

        // Mute: zeros, queue still drained
        run_master(9, 1, 1'b0, 1'b1, 1'b0, DEPTH, DEPTH, "R7 mute zeros");
        check(!push_full, "R7", "queue drained while muted", push_full, 0);

        // Stop: zeros, queue untouched
        run_master(9, 1, 1'b0, 1'b0, 1'b1, DEPTH, 4, "R8 stop zeros");
        check(push_full, "R8", "queue untouched while stopped", push_full, 1);

        // Underflow then clear
        run_master(12, 1, 1'b0, 1'b0, 1'b0, 4, 6, "R9 underflow zeros");
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            push_valid = 1'b1;
            push_data  = $urandom;
        end
        @(negedge clk);
        push_valid = 1'b0;
        check(push_full, "R12", "full after depth pushes", push_full, 1);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = cfg(12, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        ctl_wr = 1'b0;
        clk_en = 1'b1;
        begin
            int toggles = 0;
            repeat (6) begin
                @(negedge clk);
                if (sck_out) toggles++;
            end
            check(toggles == 0, "R10", "bit clock held during clear", toggles, 0);
        end
        clk_en = 1'b0;
        check(!underflow, "R10", "underflow cleared", underflow, 0);
        check(!push_full, "R10", "queue emptied by clear", push_full, 0);

        // Push while full is dropped
        setup(15, 1, 1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        push_valid = 1'b1;
        for (int i = 0; i < DEPTH + 1; i++) begin
            push_data = smp[i];
            @(negedge clk);
        end
        push_valid = 1'b0;
        check(push_full, "R12", "full after overfill", push_full, 1);
        write_ctl(cfg(15, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        m_silent = 1'b0;
        m_n = DEPTH;
        cap_master(1 + (DEPTH + 1) * 16);
        compare(1 + (DEPTH + 1) * 16, "R12 dropped ninth word not sent");
        check(underflow, "R9", "underflow after dropped word", underflow, 1);

        // Slave role
        setup(13, 1, 1'b0, 1'b0, 1'b0, 1'b1);
        m_n = 6;
        fork
            feed(6);
            begin
                repeat (3) @(negedge clk);
                cap_slave(1 + 6 * 14);
            end
        join
        compare(1 + 6 * 14, "R11 slave 16-bit stereo");
        setup(25, 0, 1'b1, 1'b0, 1'b0, 1'b1);
        m_n = 2;
        fork
            feed(2);
            begin
                repeat (3) @(negedge clk);
                cap_slave(1 + 4 * 26);
            end
        join
        compare(1 + 4 * 26, "R11 slave 8-bit mono padded");

        // Random configurations, samples fed during framing
        for (int r = 0; r < 6; r++) begin
            int  half  = 4 + ($urandom % 40);
            int  pick  = $urandom % 3;
            int  wcode = (pick == 0) ? 0 : (pick == 1) ? 1 : 3;
            bit  mono  = bit'($urandom % 2);
            run_master(half, wcode, mono, 1'b0, 1'b0, mono ? 6 : 12, 12,
                       "R2 R5 R6 random push-pop overlap");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule